// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 64-bit virtual address into a physical address and a set of read, write and execute permissions. It walks a three-level page table held in memory. It has one memory read port, and that port carries at most one read at a time. The walk starts from a table base address that the requester supplies. A requester hands over the address, a privilege mode index (0 = most privileged), a physical-access flag and the kind of access it needs. Some time later the block returns a one-cycle done pulse with either a translation or a fault code.

Three cases finish without touching memory. In the physical-access case the address passes straight through. An address that is not properly sign-extended is refused. A negative address in the direct-mapped kernel window is remapped in fixed logic. Every other address takes three dependent table reads. The intermediate entries must be valid and kernel-readable. The leaf entry's permission bits are selected by the mode index and are then reduced by its fault-on-access bits.

Top module: `tbl_walker`

## Requirements
- R1: `req_ready_o` is high exactly when the block is idle. A request is taken on the clock edge where `req_valid_i` and `req_ready_o` are both high. Address, mode, physical flag, need and `ptbase_i` are captured on that edge, so later input changes do not affect the walk. `req_ready_o` stays low until `done_o`.
- R2: `done_o` is a single-cycle pulse. `fault_code_o` encodes 0 success, 1 entry not valid, 2 access violation, 3 fault on read, 4 fault on write, 5 fault on execute. On any fault, `paddr_o` and `perm_o` are zero. Permission bits and need bits share one layout: bit 0 read, bit 1 write, bit 2 execute.
- R3: With `req_phys_i` high, `paddr_o` equals the virtual address and `perm_o` is 3'b111. No memory read is made, and `done_o` rises two cycles after the accepting edge.
- R4: When the flag is low and bits 63:43 of the address are not all equal, the result is an access violation. No read is made, and the result has the same two-cycle timing.
- R5: An address that passes R4, has bit 63 set and has bits 42:41 equal to 2'b10 is mapped directly. In mode 0, `paddr_o` carries address bits 39:0 in place, address bit 40 at bit 43 and zeros elsewhere, and `perm_o` is 3'b111. Any other mode gets an access violation. No read is made in either case.
- R6: Any other address is walked. The table index for levels 1, 2 and 3 is address bits 42:33, 32:23 and 22:13. Each entry is read at table base + index*8. Level 1 uses the captured `ptbase_i`. Each later level uses the previous entry's bits 63:32 shifted left by 13.
- R7: At levels 1 and 2, an entry with bit 0 clear ends the walk with code 1. An entry with bit 8 clear ends it with code 2. No further read follows either fault.
- R8: At level 3, bit 0 clear gives code 1. Bit 8+mode grants read and execute, and bit 12+mode grants write. A nonzero need that shares no bit with these grants gives code 2.
- R9: Leaf entry bits 1, 2 and 3 remove read, write and execute. If a nonzero need then shares no bit with the result, the code is 5 when the need includes execute, else 4 when it includes write, else 3. A need of zero never faults at the leaf. On success, `paddr_o` = (entry bits 63:32 << 13) | address bits 12:0, and `perm_o` is the reduced permission.
- R10: `mem_req_o` is a one-cycle pulse with `mem_addr_o` valid. No new read is issued before `mem_rvalid_i` answers the previous one. `done_o` rises one cycle after the `mem_rvalid_i` that ends the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_vaddr_i | input | 64 | Virtual address |
| req_mode_i | input | 2 | Privilege mode index, 0 most privileged |
| req_phys_i | input | 1 | Physical access, no translation |
| req_need_i | input | 3 | Needed access: bit 0 read, bit 1 write, bit 2 execute |
| ptbase_i | input | 64 | Level-1 table base address |
| mem_req_o | output | 1 | Table read request pulse |
| mem_addr_o | output | 64 | Table entry address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Table entry read |
| done_o | output | 1 | Result pulse |
| fault_code_o | output | 3 | Result code (see R2) |
| paddr_o | output | 64 | Physical address |
| perm_o | output | 3 | Granted permissions |

## Verification
Requests that bypass the walk must raise `done_o` exactly two cycles after the accepting edge. A walked request must raise it exactly one cycle after the `mem_rvalid_i` of its final read. The bench recomputes each expected result, and each expected entry address, from the requirements. On every falling edge it compares `mem_req_o`/`mem_addr_o` against that address queue and flags any `done_o` that arrives in a cycle other than the predicted one. The bench memory answers after a latency chosen per request (1 to 3 cycles), so the response-driven timing is exercised under more than one delay.

// File: rtl/tbl_walker_pkg.sv
package tbl_walker_pkg;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_NOT_VALID = 3'd1,
    FLT_ACCESS    = 3'd2,
    FLT_ON_READ   = 3'd3,
    FLT_ON_WRITE  = 3'd4,
    FLT_ON_EXEC   = 3'd5
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_REQ,
    ST_WAIT
  } walk_st_e;

  // permission / need bit positions
  localparam int unsigned PERM_R = 0;
  localparam int unsigned PERM_W = 1;
  localparam int unsigned PERM_X = 2;

  // table entry fields
  localparam int unsigned PTE_VALID = 0;
  localparam int unsigned PTE_FO_LO = 1;   // fault-on read/write/exec at 1..3
  localparam int unsigned PTE_RD_EN = 8;   // read enable, mode 0
  localparam int unsigned PTE_WR_EN = 12;  // write enable, mode 0
  localparam int unsigned PTE_FRAME = 32;

  // direct-mapped kernel window
  localparam int unsigned DM_SEL_LO = 41;
  localparam int unsigned DM_KEEP_W = 40;
  localparam int unsigned DM_MOVE   = 43;

endpackage

// File: rtl/ptw_pre_check.sv
module ptw_pre_check
  import tbl_walker_pkg::*;
#(
  parameter int unsigned VA_BITS = 43
) (
  input  logic [63:0] vaddr_i,
  input  logic [1:0]  mode_i,
  input  logic        phys_i,
  output logic        bypass_o,
  output fault_e      code_o,
  output logic [63:0] paddr_o,
  output logic [2:0]  perm_o
);

  localparam int unsigned HI_W = 64 - VA_BITS;

  logic [HI_W-1:0] hi_bits;
  logic            sign_ok;
  logic            dm_hit;

  assign hi_bits = vaddr_i[63:VA_BITS];
  assign sign_ok = (&hi_bits) | ~(|hi_bits);
  assign dm_hit  = vaddr_i[63] && (vaddr_i[DM_SEL_LO+1:DM_SEL_LO] == 2'b10);

  always_comb begin
    bypass_o = 1'b0;
    code_o   = FLT_NONE;
    paddr_o  = '0;
    perm_o   = '0;
    if (phys_i) begin
      bypass_o = 1'b1;
      paddr_o  = vaddr_i;
      perm_o   = 3'b111;
    end else if (!sign_ok) begin
      bypass_o = 1'b1;
      code_o   = FLT_ACCESS;
    end else if (dm_hit) begin
      bypass_o = 1'b1;
      if (mode_i != 2'd0) begin
        code_o = FLT_ACCESS;
      end else begin
        paddr_o[DM_KEEP_W-1:0] = vaddr_i[DM_KEEP_W-1:0];
        paddr_o[DM_MOVE]       = vaddr_i[DM_KEEP_W];
        perm_o                 = 3'b111;
      end
    end
  end

endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned IDX_BITS  = 10,
  parameter int unsigned LEVELS    = 3,
  parameter int unsigned VA_BITS   = PAGE_BITS + IDX_BITS * LEVELS,
  parameter int unsigned LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [63:0]        base_i,
  input  logic [VA_BITS-1:0] vaddr_i,
  input  logic [LVL_W-1:0]   level_i,
  output logic [63:0]        addr_o
);

  logic [IDX_BITS-1:0] idx_lvl [LEVELS];
  logic [IDX_BITS-1:0] idx_sel;

  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx_lvl[l] = vaddr_i[PAGE_BITS + IDX_BITS*(LEVELS-1-l) +: IDX_BITS];
  end

  always_comb begin
    idx_sel = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (level_i == LVL_W'(l)) idx_sel = idx_lvl[l];
    end
  end

  assign addr_o = base_i + (64'(idx_sel) << 3);

endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
  import tbl_walker_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 13
) (
  input  logic [63:0]          pte_i,
  input  logic [1:0]           mode_i,
  input  logic [2:0]           need_i,
  input  logic [PAGE_BITS-1:0] offset_i,
  output fault_e               code_o,
  output logic [63:0]          paddr_o,
  output logic [2:0]           perm_o
);

  logic       rd_en, wr_en;
  logic [2:0] grant, masked;

  assign rd_en  = pte_i[PTE_RD_EN + 32'(mode_i)];
  assign wr_en  = pte_i[PTE_WR_EN + 32'(mode_i)];
  assign grant  = {rd_en, wr_en, rd_en};
  assign masked = grant & ~pte_i[PTE_FO_LO +: 3];

  always_comb begin
    code_o  = FLT_NONE;
    paddr_o = '0;
    perm_o  = '0;
    if (!pte_i[PTE_VALID]) begin
      code_o = FLT_NOT_VALID;
    end else if ((need_i != 3'd0) && ((grant & need_i) == 3'd0)) begin
      code_o = FLT_ACCESS;
    end else if ((need_i != 3'd0) && ((masked & need_i) == 3'd0)) begin
      // execute outranks write outranks read
      if (need_i[PERM_X])      code_o = FLT_ON_EXEC;
      else if (need_i[PERM_W]) code_o = FLT_ON_WRITE;
      else                     code_o = FLT_ON_READ;
    end else begin
      paddr_o = (64'(pte_i[63:PTE_FRAME]) << PAGE_BITS) | 64'(offset_i);
      perm_o  = masked;
    end
  end

endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
  import tbl_walker_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned IDX_BITS  = 10,
  parameter int unsigned LEVELS    = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [63:0] req_vaddr_i,
  input  logic [1:0]  req_mode_i,
  input  logic        req_phys_i,
  input  logic [2:0]  req_need_i,
  input  logic [63:0] ptbase_i,
  output logic        mem_req_o,
  output logic [63:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [63:0] mem_rdata_i,
  output logic        done_o,
  output logic [2:0]  fault_code_o,
  output logic [63:0] paddr_o,
  output logic [2:0]  perm_o
);

  localparam int unsigned VA_BITS = PAGE_BITS + IDX_BITS * LEVELS;
  localparam int unsigned LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_st_e         st_q;
  logic [63:0]      va_q, base_q;
  logic [1:0]       mode_q;
  logic             phys_q;
  logic [2:0]       need_q;
  logic [LVL_W-1:0] lvl_q;
  logic             done_q;
  fault_e           code_q;
  logic [63:0]      pa_q;
  logic [2:0]       perm_q;

  logic        pre_bypass;
  fault_e      pre_code;
  logic [63:0] pre_pa;
  logic [2:0]  pre_perm;
  fault_e      leaf_code;
  logic [63:0] leaf_pa;
  logic [2:0]  leaf_perm;
  fault_e      mid_code;
  logic [63:0] next_base;

  logic        fin_vld;
  fault_e      fin_code;
  logic [63:0] fin_pa;
  logic [2:0]  fin_perm;

  ptw_pre_check #(.VA_BITS(VA_BITS)) u_pre (
    .vaddr_i (va_q),
    .mode_i  (mode_q),
    .phys_i  (phys_q),
    .bypass_o(pre_bypass),
    .code_o  (pre_code),
    .paddr_o (pre_pa),
    .perm_o  (pre_perm)
  );

  ptw_entry_addr #(
    .PAGE_BITS(PAGE_BITS),
    .IDX_BITS (IDX_BITS),
    .LEVELS   (LEVELS),
    .VA_BITS  (VA_BITS),
    .LVL_W    (LVL_W)
  ) u_addr (
    .base_i (base_q),
    .vaddr_i(va_q[VA_BITS-1:0]),
    .level_i(lvl_q),
    .addr_o (mem_addr_o)
  );

  ptw_leaf_eval #(.PAGE_BITS(PAGE_BITS)) u_leaf (
    .pte_i   (mem_rdata_i),
    .mode_i  (mode_q),
    .need_i  (need_q),
    .offset_i(va_q[PAGE_BITS-1:0]),
    .code_o  (leaf_code),
    .paddr_o (leaf_pa),
    .perm_o  (leaf_perm)
  );

  // upper levels only need valid and kernel read
  always_comb begin
    if (!mem_rdata_i[PTE_VALID])      mid_code = FLT_NOT_VALID;
    else if (!mem_rdata_i[PTE_RD_EN]) mid_code = FLT_ACCESS;
    else                              mid_code = FLT_NONE;
  end

  assign next_base = 64'(mem_rdata_i[63:PTE_FRAME]) << PAGE_BITS;

  always_comb begin
    fin_vld  = 1'b0;
    fin_code = FLT_NONE;
    fin_pa   = '0;
    fin_perm = '0;
    unique case (st_q)
      ST_PRE: begin
        if (pre_bypass) begin
          fin_vld  = 1'b1;
          fin_code = pre_code;
          fin_pa   = pre_pa;
          fin_perm = pre_perm;
        end
      end
      ST_WAIT: begin
        if (mem_rvalid_i) begin
          if (lvl_q == LAST_LVL) begin
            fin_vld  = 1'b1;
            fin_code = leaf_code;
            fin_pa   = leaf_pa;
            fin_perm = leaf_perm;
          end else if (mid_code != FLT_NONE) begin
            fin_vld  = 1'b1;
            fin_code = mid_code;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      va_q   <= '0;
      base_q <= '0;
      mode_q <= '0;
      phys_q <= 1'b0;
      need_q <= '0;
      lvl_q  <= '0;
      done_q <= 1'b0;
      code_q <= FLT_NONE;
      pa_q   <= '0;
      perm_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (fin_vld) begin
        done_q <= 1'b1;
        code_q <= fin_code;
        pa_q   <= fin_pa;
        perm_q <= fin_perm;
      end
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q   <= req_vaddr_i;
            mode_q <= req_mode_i;
            phys_q <= req_phys_i;
            need_q <= req_need_i;
            base_q <= ptbase_i;
            lvl_q  <= '0;
            st_q   <= ST_PRE;
          end
        end
        ST_PRE:  st_q <= pre_bypass ? ST_IDLE : ST_REQ;
        ST_REQ:  st_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            if (fin_vld) begin
              st_q <= ST_IDLE;
            end else begin
              base_q <= next_base;
              lvl_q  <= lvl_q + 1'b1;
              st_q   <= ST_REQ;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (st_q == ST_IDLE);
  assign mem_req_o    = (st_q == ST_REQ);
  assign done_o       = done_q;
  assign fault_code_o = code_q;
  assign paddr_o      = pa_q;
  assign perm_o       = perm_q;

  // R10
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R10
  req_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !done_o);

  // R1
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_code_o != 3'd0) |-> (paddr_o == 64'd0 && perm_o == 3'd0));

  // R2
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fault_code_o <= 3'd5));

  // R9
  grant_need_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_code_o == 3'd0) |-> (need_q == 3'd0 || (perm_o & need_q) != 3'd0));

endmodule

// File: tb/tbl_walker_tb_top.sv
`timescale 1ns/1ps
module tbl_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_mode = '0;
  logic        req_phys = 1'b0;
  logic [2:0]  req_need = '0;
  logic [63:0] ptbase = '0;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        done;
  logic [2:0]  fault_code;
  logic [63:0] paddr;
  logic [2:0]  perm;

  int checks = 0;
  int failures = 0;

  logic [63:0] pmem [logic [63:0]];
  logic [63:0] exp_q [$];

  always #4 clk = ~clk;

  tbl_walker dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_vaddr_i (req_vaddr),
    .req_mode_i  (req_mode),
    .req_phys_i  (req_phys),
    .req_need_i  (req_need),
    .ptbase_i    (ptbase),
    .mem_req_o   (mem_req),
    .mem_addr_o  (mem_addr),
    .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i (mem_rdata),
    .done_o      (done),
    .fault_code_o(fault_code),
    .paddr_o     (paddr),
    .perm_o      (perm)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    return pmem.exists(a) ? pmem[a] : 64'd0;
  endfunction

  // behavioural reference of the requirements
  task automatic model(input logic [63:0] va, input logic [1:0] mode, input logic phys,
                       input logic [2:0] need, input logic [63:0] base,
                       output logic [2:0] code, output logic [63:0] pa,
                       output logic [2:0] pm);
    logic [63:0] b, a, e;
    logic [2:0]  g, m;
    code = 3'd0; pa = '0; pm = '0;
    if (phys) begin
      pa = va; pm = 3'b111; return;
    end
    if (va[63:43] != {21{va[63]}}) begin
      code = 3'd2; return;
    end
    if (va[63] && va[42:41] == 2'b10) begin
      if (mode != 2'd0) code = 3'd2;
      else begin
        pa = (va & ((64'd1 << 40) - 1)) | (64'(va[40]) << 43);
        pm = 3'b111;
      end
      return;
    end
    b = base;
    for (int lv = 0; lv < 3; lv++) begin
      a = b + (((va >> (13 + 10 * (2 - lv))) & 64'h3ff) * 8);
      exp_q.push_back(a);
      e = rd(a);
      if (!e[0]) begin code = 3'd1; return; end
      if (lv < 2) begin
        if (!e[8]) begin code = 3'd2; return; end
        b = (e >> 32) << 13;
      end
    end
    g = 3'd0;
    if (e[8 + mode])  g = g | 3'b101;
    if (e[12 + mode]) g = g | 3'b010;
    if (need != 0 && (g & need) == 0) begin code = 3'd2; return; end
    m = g & ~e[3:1];
    if (need != 0 && (m & need) == 0) begin
      code = need[2] ? 3'd5 : (need[1] ? 3'd4 : 3'd3);
      return;
    end
    pa = ((e >> 32) << 13) | (va & 64'h1fff);
    pm = m;
  endtask

  task automatic run(input string tag, input logic [63:0] va, input logic [1:0] mode,
                     input logic phys, input logic [2:0] need, input logic [63:0] base,
                     input int lat);
    logic [2:0]  e_code, e_perm;
    logic [63:0] e_pa, pend_a;
    int nrd, t, pend, last_rv, exp_t;
    bit seen;
    exp_q.delete();
    model(va, mode, phys, need, base, e_code, e_pa, e_perm);
    nrd = exp_q.size();
    @(negedge clk);
    chk("R1", "ready before request", 64'(req_ready), 64'd1);
    req_vaddr = va; req_mode = mode; req_phys = phys; req_need = need; ptbase = base;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // disturb inputs after acceptance: captured values must be used (R1)
    req_vaddr = ~va; req_mode = ~mode; req_phys = ~phys; req_need = ~need; ptbase = ~base;
    chk("R1", "ready while busy", 64'(req_ready), 64'd0);
    t = 1; pend = 0; last_rv = 0; seen = 0; pend_a = '0;
    while (!seen && t < 100) begin
      @(negedge clk);
      t++;
      mem_rvalid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rvalid = 1'b1; mem_rdata = rd(pend_a); last_rv = t;
        end
      end
      if (mem_req) begin
        if (exp_q.size() == 0) begin
          chk("R10", "unexpected read", mem_addr, 64'hdead);
        end else begin
          chk("R6", "entry address", mem_addr, exp_q.pop_front());
        end
        chk("R10", "read while outstanding", 64'(pend), 64'd0);
        pend_a = mem_addr; pend = lat;
      end
      if (done) begin
        seen = 1;
        exp_t = (nrd == 0) ? 2 : last_rv + 1;
        chk((nrd == 0) ? "R3" : "R10", "done cycle", 64'(t), 64'(exp_t));
        chk(tag, "fault code", 64'(fault_code), 64'(e_code));
        chk(tag, "paddr", paddr, e_pa);
        chk(tag, "perm", 64'(perm), 64'(e_perm));
        chk("R6", "reads left", 64'(exp_q.size()), 64'd0);
      end
    end
    if (!seen) chk("R10", "no done", 64'd0, 64'd1);
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk("R2", "done pulse width", 64'(done), 64'd0);
    chk("R1", "ready after done", 64'(req_ready), 64'd1);
  endtask

  function automatic logic [63:0] mk_va(input int l1, input int l2, input int l3, input int off);
    return (64'(l1) << 33) | (64'(l2) << 23) | (64'(l3) << 13) | 64'(off);
  endfunction

  localparam logic [63:0] BASE = 64'h10000;
  localparam logic [63:0] T2   = 64'h40000;
  localparam logic [63:0] T3   = 64'h60000;

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // tables
    pmem[BASE + 3*8]  = {32'h20, 32'h101};
    pmem[BASE + 4*8]  = {32'h20, 32'h001};    // kernel read clear
    pmem[T2 + 5*8]    = {32'h30, 32'h101};
    pmem[T3 + 7*8]    = {32'hABCD, 32'h1901}; // kernel rw, mode 3 read
    pmem[T3 + 8*8]    = {32'hABCE, 32'h1109}; // exec faults
    pmem[T3 + 9*8]    = {32'hABCF, 32'h1105}; // write faults
    pmem[T3 + 10*8]   = {32'hABD0, 32'h1107}; // read+write fault
    pmem[T3 + 11*8]   = {32'hABD1, 32'h110F}; // all fault
    pmem[T3 + 12*8]   = {32'hABD2, 32'h1103}; // read faults

    repeat (3) @(negedge clk);
    chk("R1", "reset ready", 64'(req_ready), 64'd1);
    chk("R2", "reset done", 64'(done), 64'd0);
    chk("R10", "reset mem_req", 64'(mem_req), 64'd0);
    rst_n = 1'b1;

    run("R9", mk_va(3, 5, 7, 'h123), 2'd0, 0, 3'b001, BASE, 1);
    run("R9", mk_va(3, 5, 7, 'h1ff), 2'd0, 0, 3'b010, BASE, 3);
    run("R8", mk_va(3, 5, 7, 'h010), 2'd3, 0, 3'b010, BASE, 2);
    run("R8", mk_va(3, 5, 7, 'h010), 2'd3, 0, 3'b001, BASE, 1);
    run("R8", mk_va(3, 5, 7, 'h010), 2'd1, 0, 3'b001, BASE, 2);
    run("R9", mk_va(3, 5, 8, 'h0), 2'd0, 0, 3'b100, BASE, 1);
    run("R9", mk_va(3, 5, 8, 'h0), 2'd0, 0, 3'b001, BASE, 2);
    run("R9", mk_va(3, 5, 9, 'h4), 2'd0, 0, 3'b010, BASE, 1);
    run("R9", mk_va(3, 5, 9, 'h4), 2'd0, 0, 3'b110, BASE, 1);
    run("R9", mk_va(3, 5, 10, 'h8), 2'd0, 0, 3'b011, BASE, 2);
    run("R9", mk_va(3, 5, 11, 'h8), 2'd0, 0, 3'b111, BASE, 1);
    run("R9", mk_va(3, 5, 12, 'h8), 2'd0, 0, 3'b001, BASE, 3);
    run("R9", mk_va(3, 5, 11, 'h8), 2'd0, 0, 3'b000, BASE, 1);
    run("R8", mk_va(3, 5, 13, 'h0), 2'd0, 0, 3'b001, BASE, 1);
    run("R7", mk_va(3, 6, 7, 'h0), 2'd0, 0, 3'b001, BASE, 2);
    run("R7", mk_va(4, 5, 7, 'h0), 2'd0, 0, 3'b001, BASE, 1);
    run("R7", mk_va(9, 5, 7, 'h0), 2'd0, 0, 3'b001, BASE, 1);
    run("R6", mk_va(3, 5, 7, 'h0), 2'd0, 0, 3'b001, 64'h90000, 1);
    run("R3", 64'hFFFF_0000_1234_5678, 2'd3, 1, 3'b010, BASE, 1);
    run("R4", 64'h0000_0800_0000_0000, 2'd0, 0, 3'b001, BASE, 1);
    run("R4", 64'hFFFF_F000_0000_0000 ^ 64'h8000_0000_0000_0000, 2'd0, 0, 3'b001, BASE, 1);
    run("R6", 64'h0000_0400_0000_0000, 2'd0, 0, 3'b001, BASE, 1);
    run("R5", 64'hFFFF_FD12_3456_789A, 2'd0, 0, 3'b100, BASE, 1);
    run("R5", 64'hFFFF_FC12_3456_789A, 2'd0, 0, 3'b001, BASE, 1);
    run("R5", 64'hFFFF_FD12_3456_789A, 2'd2, 0, 3'b001, BASE, 1);
    run("R6", 64'hFFFF_FE00_0000_2000, 2'd0, 0, 3'b001, BASE, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule